// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is a single DMA channel that copies data by following a chain of descriptors kept in memory. Software programs a descriptor pointer, sets the direction and interrupt enable in a mode register, and then writes the enable and go bits together into the status register. The channel reads the four-word descriptor at the pointer, moves the described number of bytes one word at a time over a simple memory port, and then either follows the descriptor's link to the next descriptor or stops.

A descriptor is four words at consecutive word addresses. In order they are: the system-side address, the device-side address, the byte count, and the link. Bit 0 of the link marks the last descriptor. Completion sets a sticky done flag, which software clears by writing it back as 1. The interrupt line is that flag qualified by the interrupt enable bit. An abort command stops the channel at once, drops the enable bit and never sets the done flag.

The memory port has a fixed one-cycle read latency and no stall. A read is issued in one cycle, and its data is valid on `mem_rdata` in the next cycle.

Top module: `dma_chain_ctrl`

State machine: `ST_IDLE` → `ST_FETCH_REQ` on *go*. Then `ST_FETCH_REQ` → `ST_FETCH_CAP` (*issue*). From `ST_FETCH_CAP`, the machine takes *next word* back to `ST_FETCH_REQ`, *empty* to `ST_DESC_END` when the count is zero, or *payload* to `ST_MOVE_RD`. Then `ST_MOVE_RD` → `ST_MOVE_WR` (*read issued*). From `ST_MOVE_WR`, the machine takes *more* back to `ST_MOVE_RD` or *drained* to `ST_DESC_END`. From `ST_DESC_END`, the machine takes *link* to `ST_FETCH_REQ` or *last* to `ST_IDLE`. From any state, *abort* leads to `ST_IDLE`.

## Requirements
- R1: After reset every register reads 0, `irq` is low and the memory port is idle.
- R2: A status write with bit 0 (enable) = 1 and bit 1 (go) = 1 while the channel is idle starts a fetch at the descriptor pointer in the next cycle. A go write with bit 0 = 0 starts nothing.
- R3: A descriptor holds 4 words at ptr, ptr+4, ptr+8 and ptr+12: system address, device address, byte count (its low 2 bits are ignored), and link. Link bit 0 = 1 ends the chain. Otherwise the next descriptor is at the link with its low 4 bits cleared.
- R4: Mode bit 1 = 1 copies from the system address to the device address. Mode bit 1 = 0 copies the other way. Each word takes one read cycle and one write cycle, and the port never reads and writes in the same cycle.
- R5: Each descriptor occupies the channel for 9 + 2·words cycles. The done flag (status bit 3) is set in the cycle that the last descriptor ends, and busy (status bit 5) falls at the same time.
- R6: Writing 1 to status bit 3 clears the done flag, and writing 1 to bit 4 clears the descriptor-done flag. Writing 0 to either bit leaves it unchanged.
- R7: `irq` equals the done flag AND mode bit 0.
- R8: A status write with bit 2 (abort) = 1 stops the channel from the next cycle on. It also clears enable, issues no further memory access, and never sets the done flag or raises `irq`.
- R9: Register 0x08 reads the current descriptor address and register 0x0C reads the bytes left in the current descriptor, including while the channel is busy.
- R10: Writes to the pointer (0x08), count (0x0C), system address (0x10) and device address (0x14) registers are ignored while the channel is busy.
- R11: A descriptor whose masked byte count is 0 moves no data, but it still ends normally and is followed by the next descriptor in the chain.
- R12: Status bit 4 (descriptor done) is set at the end of every descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte address |
| reg_wdata | input | W | Register write data |
| reg_rdata | output | W | Register read data (combinational) |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | W | Memory byte address |
| mem_wdata | output | W | Memory write data |
| mem_rdata | input | W | Memory read data, one cycle after `mem_rd` |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
A wrong state register or a wrong byte counter in this block changes the length of the transfer. At the ports, this appears as the done flag and `irq` rising one or more cycles too early or too late. The bench therefore compares `irq` against a cycle-count model on every clock, so a timing error is reported in the very cycle it occurs. A wrong address or data path leaves wrong words or stray writes in memory. These are caught when a chain ends, by comparing the destination buffers and their untouched guard words.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_REQ,
        ST_FETCH_CAP,
        ST_MOVE_RD,
        ST_MOVE_WR,
        ST_DESC_END
    } chan_state_e;

    // register word indices (byte address / 4)
    localparam logic [2:0] RIDX_STATUS = 3'd0;
    localparam logic [2:0] RIDX_MODE   = 3'd1;
    localparam logic [2:0] RIDX_PTR    = 3'd2;
    localparam logic [2:0] RIDX_COUNT  = 3'd3;
    localparam logic [2:0] RIDX_SADDR  = 3'd4;
    localparam logic [2:0] RIDX_DADDR  = 3'd5;

    // status bit positions
    localparam int SB_EN    = 0;
    localparam int SB_GO    = 1;
    localparam int SB_ABORT = 2;
    localparam int SB_DONE  = 3;
    localparam int SB_DDONE = 4;
    localparam int SB_BUSY  = 5;

    // mode bit positions
    localparam int MB_IEN   = 0;
    localparam int MB_TODEV = 1;

endpackage

// File: rtl/dma_chain_regs.sv
module dma_chain_regs
    import dma_chain_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_wr,
    input  logic [2:0]   reg_idx,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    input  logic         busy,
    input  logic         desc_end,
    input  logic         chain_end,
    input  logic [W-1:0] cur_ptr,
    input  logic [W-1:0] cur_cnt,
    input  logic [W-1:0] cur_saddr,
    input  logic [W-1:0] cur_daddr,
    output logic         go,
    output logic         abort,
    output logic         ld_ptr,
    output logic         ld_cnt,
    output logic         ld_saddr,
    output logic         ld_daddr,
    output logic         ien,
    output logic         to_dev,
    output logic         done_flag
);

    logic en_q, ddone_q, done_q, ien_q, todev_q;
    logic wr_status, wr_mode;

    assign wr_status = reg_wr && (reg_idx == RIDX_STATUS);
    assign wr_mode   = reg_wr && (reg_idx == RIDX_MODE);

    assign abort    = wr_status && reg_wdata[SB_ABORT];
    assign go       = wr_status && reg_wdata[SB_GO] && reg_wdata[SB_EN] && !busy;
    assign ld_ptr   = reg_wr && (reg_idx == RIDX_PTR)   && !busy;
    assign ld_cnt   = reg_wr && (reg_idx == RIDX_COUNT) && !busy;
    assign ld_saddr = reg_wr && (reg_idx == RIDX_SADDR) && !busy;
    assign ld_daddr = reg_wr && (reg_idx == RIDX_DADDR) && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            done_q  <= 1'b0;
            ddone_q <= 1'b0;
            ien_q   <= 1'b0;
            todev_q <= 1'b0;
        end else begin
            if (wr_status)
                en_q <= reg_wdata[SB_EN] && !reg_wdata[SB_ABORT];
            if (chain_end)
                done_q <= 1'b1;
            else if (wr_status && reg_wdata[SB_DONE])
                done_q <= 1'b0;
            if (desc_end)
                ddone_q <= 1'b1;
            else if (wr_status && reg_wdata[SB_DDONE])
                ddone_q <= 1'b0;
            if (wr_mode) begin
                ien_q   <= reg_wdata[MB_IEN];
                todev_q <= reg_wdata[MB_TODEV];
            end
        end
    end

    assign ien       = ien_q;
    assign to_dev    = todev_q;
    assign done_flag = done_q;

    always_comb begin
        reg_rdata = '0;
        case (reg_idx)
            RIDX_STATUS: begin
                reg_rdata[SB_EN]    = en_q;
                reg_rdata[SB_DONE]  = done_q;
                reg_rdata[SB_DDONE] = ddone_q;
                reg_rdata[SB_BUSY]  = busy;
            end
            RIDX_MODE: begin
                reg_rdata[MB_IEN]   = ien_q;
                reg_rdata[MB_TODEV] = todev_q;
            end
            RIDX_PTR:   reg_rdata = cur_ptr;
            RIDX_COUNT: reg_rdata = cur_cnt;
            RIDX_SADDR: reg_rdata = cur_saddr;
            RIDX_DADDR: reg_rdata = cur_daddr;
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
    import dma_chain_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic         abort,
    input  logic         to_dev,
    input  logic         ld_ptr,
    input  logic         ld_cnt,
    input  logic         ld_saddr,
    input  logic         ld_daddr,
    input  logic [W-1:0] ld_data,
    input  logic [W-1:0] mem_rdata,
    output logic         mem_rd,
    output logic         mem_wr,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata,
    output logic         busy,
    output logic         desc_end,
    output logic         chain_end,
    output logic [W-1:0] cur_ptr,
    output logic [W-1:0] cur_cnt,
    output logic [W-1:0] cur_saddr,
    output logic [W-1:0] cur_daddr
);

    localparam int STEP       = W / 8;
    localparam int LSB        = $clog2(STEP);
    localparam int DESC_WORDS = 4;
    localparam int IDX_W      = $clog2(DESC_WORDS);
    localparam logic [W-1:0] STEP_V    = W'(STEP);
    localparam logic [W-1:0] CNT_MASK  = ~W'(STEP - 1);
    localparam logic [W-1:0] LINK_MASK = ~W'(DESC_WORDS * STEP - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DESC_WORDS - 1);

    chan_state_e state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [W-1:0] ptr_q, cnt_q, sad_q, dad_q, link_q;
    logic dir_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (go) state_d = ST_FETCH_REQ;
            ST_FETCH_REQ: state_d = ST_FETCH_CAP;
            ST_FETCH_CAP: begin
                if (idx_q != IDX_LAST)  state_d = ST_FETCH_REQ;
                else if (cnt_q == '0)   state_d = ST_DESC_END;
                else                    state_d = ST_MOVE_RD;
            end
            ST_MOVE_RD:   state_d = ST_MOVE_WR;
            ST_MOVE_WR:   state_d = (cnt_q == STEP_V) ? ST_DESC_END : ST_MOVE_RD;
            ST_DESC_END:  state_d = link_q[0] ? ST_IDLE : ST_FETCH_REQ;
            default:      state_d = ST_IDLE;
        endcase
        if (abort) state_d = ST_IDLE;
    end

    // outputs
    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        desc_end  = 1'b0;
        chain_end = 1'b0;
        unique case (state_q)
            ST_FETCH_REQ: begin
                mem_rd   = !abort;
                mem_addr = ptr_q + (W'(idx_q) << LSB);
            end
            ST_MOVE_RD: begin
                mem_rd   = !abort;
                mem_addr = dir_q ? sad_q : dad_q;
            end
            ST_MOVE_WR: begin
                mem_wr   = !abort;
                mem_addr = dir_q ? dad_q : sad_q;
            end
            ST_DESC_END: begin
                desc_end  = !abort;
                chain_end = !abort && link_q[0];
            end
            default: ;
        endcase
    end

    assign mem_wdata = mem_rdata;
    assign busy      = (state_q != ST_IDLE);

    // working registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            ptr_q  <= '0;
            cnt_q  <= '0;
            sad_q  <= '0;
            dad_q  <= '0;
            link_q <= '0;
            dir_q  <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            if (ld_ptr)   ptr_q <= ld_data;
            if (ld_cnt)   cnt_q <= ld_data;
            if (ld_saddr) sad_q <= ld_data;
            if (ld_daddr) dad_q <= ld_data;
            if (go) begin
                idx_q <= '0;
                dir_q <= to_dev;
            end
        end else if (!abort) begin
            unique case (state_q)
                ST_FETCH_CAP: begin
                    case (idx_q)
                        2'd0:    sad_q  <= mem_rdata;
                        2'd1:    dad_q  <= mem_rdata;
                        2'd2:    cnt_q  <= mem_rdata & CNT_MASK;
                        default: link_q <= mem_rdata;
                    endcase
                    idx_q <= idx_q + 1'b1;
                end
                ST_MOVE_WR: begin
                    cnt_q <= cnt_q - STEP_V;
                    sad_q <= sad_q + STEP_V;
                    dad_q <= dad_q + STEP_V;
                end
                ST_DESC_END: begin
                    if (!link_q[0]) ptr_q <= link_q & LINK_MASK;
                end
                default: ;
            endcase
        end
    end

    assign cur_ptr   = ptr_q;
    assign cur_cnt   = cnt_q;
    assign cur_saddr = sad_q;
    assign cur_daddr = dad_q;

endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
    import dma_chain_pkg::*;
#(
    parameter int W      = 32,
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [W-1:0]      reg_wdata,
    output logic [W-1:0]      reg_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [W-1:0]      mem_addr,
    output logic [W-1:0]      mem_wdata,
    input  logic [W-1:0]      mem_rdata,
    output logic              irq
);

    logic [2:0]   reg_idx;
    logic         busy, desc_end, chain_end;
    logic         go, abort, ld_ptr, ld_cnt, ld_saddr, ld_daddr;
    logic         ien, to_dev, done_flag;
    logic [W-1:0] cur_ptr, cur_cnt, cur_saddr, cur_daddr;

    assign reg_idx = 3'(reg_addr[REG_AW-1:2]);

    dma_chain_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_idx   (reg_idx),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .desc_end  (desc_end),
        .chain_end (chain_end),
        .cur_ptr   (cur_ptr),
        .cur_cnt   (cur_cnt),
        .cur_saddr (cur_saddr),
        .cur_daddr (cur_daddr),
        .go        (go),
        .abort     (abort),
        .ld_ptr    (ld_ptr),
        .ld_cnt    (ld_cnt),
        .ld_saddr  (ld_saddr),
        .ld_daddr  (ld_daddr),
        .ien       (ien),
        .to_dev    (to_dev),
        .done_flag (done_flag)
    );

    dma_chain_seq #(.W(W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .abort     (abort),
        .to_dev    (to_dev),
        .ld_ptr    (ld_ptr),
        .ld_cnt    (ld_cnt),
        .ld_saddr  (ld_saddr),
        .ld_daddr  (ld_daddr),
        .ld_data   (reg_wdata),
        .mem_rdata (mem_rdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .busy      (busy),
        .desc_end  (desc_end),
        .chain_end (chain_end),
        .cur_ptr   (cur_ptr),
        .cur_cnt   (cur_cnt),
        .cur_saddr (cur_saddr),
        .cur_daddr (cur_daddr)
    );

    assign irq = done_flag && ien;

endmodule

// File: rtl/dma_chain_chk.sv
module dma_chain_chk
    import dma_chain_pkg::*;
#(
    parameter int W      = 32,
    parameter int REG_AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [W-1:0]      reg_wdata,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [W-1:0]      mem_addr,
    input logic              irq,
    input logic              busy,
    input logic              done,
    input logic [W-1:0]      cur_ptr
);

    logic st_wr;
    assign st_wr = reg_wr && (3'(reg_addr[REG_AW-1:2]) == RIDX_STATUS);

    a_r2_go_fetches_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && reg_wdata[SB_GO] && reg_wdata[SB_EN] && !reg_wdata[SB_ABORT] && !busy)
        |=> (mem_rd && mem_addr == $past(cur_ptr)));

    a_r4_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    a_r1_idle_port_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr));

    a_r5_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    a_r8_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && reg_wdata[SB_ABORT]) |=> (!busy && !mem_rd && !mem_wr));

    a_r8_abort_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && reg_wdata[SB_ABORT] && !reg_wdata[SB_DONE]) |=> $stable(irq));

endmodule

bind dma_chain_ctrl dma_chain_chk #(.W(W), .REG_AW(REG_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .irq       (irq),
    .busy      (busy),
    .done      (done_flag),
    .cur_ptr   (cur_ptr)
);

// File: tb/tb_dma_chain_ctrl.sv
`timescale 1ns/1ps
module tb_dma_chain_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_rd, mem_wr;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        irq;

    always #5 clk = ~clk;

    dma_chain_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .irq(irq)
    );

    int tests = 0, fails = 0;
    logic [31:0] mem [0:255];

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[9:2]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[9:2]];
    end

    task automatic poke(input int a, input logic [31:0] v);
        mem[a[9:2]] = v;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int i);
        return 32'hA5000000 + 32'(i) * 32'h01010101;
    endfunction

    // reference model: cycle count of the active chain
    int  mdl_left = 0, mdl_plan = 0;
    bit  mdl_done = 0, mdl_ien = 0;

    always @(posedge clk) begin
        if (rst_n) begin
            bit set_now;
            set_now = 0;
            if (reg_wr && reg_addr == 5'h00 && reg_wdata[2]) mdl_left = 0;
            else if (reg_wr && reg_addr == 5'h00 && reg_wdata[1:0] == 2'b11 && mdl_left == 0)
                mdl_left = mdl_plan;
            else if (mdl_left > 0) begin
                mdl_left--;
                if (mdl_left == 0) begin mdl_done = 1; set_now = 1; end
            end
            if (reg_wr && reg_addr == 5'h00 && reg_wdata[3] && !set_now) mdl_done = 0;
            if (reg_wr && reg_addr == 5'h04) mdl_ien = reg_wdata[0];
        end
    end

    // R5/R7: interrupt compared with the model every cycle
    always @(negedge clk) begin
        if (rst_n) begin
            tests++;
            if (irq !== (mdl_done && mdl_ien)) begin
                fails++;
                $display("FAIL R5/R7 irq actual=%b expected=%b", irq, mdl_done && mdl_ien);
            end
        end
    end

    task automatic summary_and_end();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary_and_end();
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 5'h00; reg_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_addr = 5'h00;
    endtask

    task automatic launch(input logic [31:0] ptr, input logic [31:0] mode, input int cyc);
        wr(5'h10, 0);
        wr(5'h14, 0);
        wr(5'h00, 32'h19);
        wr(5'h04, mode);
        wr(5'h0C, 0);
        wr(5'h08, ptr);
        mdl_plan = cyc;
        wr(5'h00, 32'h03);
    endtask

    task automatic desc(input int a, input int s, input int d, input int n, input int lk);
        poke(a, s); poke(a + 4, d); poke(a + 8, n); poke(a + 12, lk);
    endtask

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD0000 + 32'(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(5'h00, v); chk("R1 status", v, 0);
        rd(5'h04, v); chk("R1 mode", v, 0);
        rd(5'h08, v); chk("R1 ptr", v, 0);
        rd(5'h0C, v); chk("R1 count", v, 0);
        chk("R1 irq", 32'(irq), 0);

        // R2 R3 R4 R5 R7 single descriptor, system -> device, 3 words
        for (int i = 0; i < 3; i++) poke(32'h100 + 4 * i, pat(i));
        desc(32'h000, 32'h100, 32'h200, 12, 1);
        launch(32'h000, 32'h3, 15);
        repeat (18) @(negedge clk);
        for (int i = 0; i < 3; i++) chk("R4 to-device data", mem[(32'h200 >> 2) + i], pat(i));
        chk("R3 guard past count", mem[(32'h20C >> 2)], 32'hDEAD0000 + 32'h83);
        rd(5'h00, v); chk("R5 done set busy clear", v & 32'h29, 32'h09);
        chk("R12 desc done", 32'(v[4]), 1);
        rd(5'h0C, v); chk("R9 count drained", v, 0);
        chk("R7 irq with enable", 32'(irq), 1);

        // R6 write-one-to-clear
        wr(5'h00, 32'h08);
        rd(5'h00, v); chk("R6 done cleared", 32'(v[3]), 0);
        chk("R6 ddone kept", 32'(v[4]), 1);
        wr(5'h00, 32'h10);
        rd(5'h00, v); chk("R6 ddone cleared", 32'(v[4]), 0);

        // R3 R4 R11 three-link chain, device -> system, zero-size middle, masked count
        poke(32'h280, pat(10)); poke(32'h284, pat(11)); poke(32'h2A0, pat(12));
        desc(32'h040, 32'h300, 32'h280, 8, 32'h060);
        desc(32'h060, 32'h310, 32'h290, 2, 32'h08E);
        desc(32'h080, 32'h320, 32'h2A0, 6, 32'h001);
        launch(32'h040, 32'h1, 33);
        repeat (36) @(negedge clk);
        chk("R4 from-device w0", mem[32'h300 >> 2], pat(10));
        chk("R4 from-device w1", mem[32'h304 >> 2], pat(11));
        chk("R11 zero-size moves nothing", mem[32'h310 >> 2], 32'hDEAD0000 + 32'hC4);
        chk("R3 masked count", mem[32'h320 >> 2], pat(12));
        chk("R3 masked count guard", mem[32'h324 >> 2], 32'hDEAD0000 + 32'hC9);
        rd(5'h08, v); chk("R9 ptr at last desc", v, 32'h080);
        chk("R7 irq", 32'(irq), 1);

        // R7 done without interrupt enable
        launch(32'h000, 32'h2, 15);
        repeat (18) @(negedge clk);
        rd(5'h00, v); chk("R7 done set", 32'(v[3]), 1);
        chk("R7 irq masked", 32'(irq), 0);

        // R2 go without enable starts nothing
        wr(5'h00, 32'h08);
        poke(32'h200, 32'h0BAD0BAD);
        mdl_plan = 15;
        wr(5'h00, 32'h02);
        repeat (20) @(negedge clk);
        rd(5'h00, v); chk("R2 no start busy", 32'(v[5]), 0);
        chk("R2 no start data", mem[32'h200 >> 2], 32'h0BAD0BAD);

        // R8 R9 R10 abort of a long descriptor
        desc(32'h0C0, 32'h100, 32'h380, 64, 1);
        launch(32'h0C0, 32'h3, 41);
        repeat (14) @(negedge clk);
        wr(5'h08, 32'h3F0);
        rd(5'h08, v); chk("R10 ptr write ignored while busy", v, 32'h0C0);
        rd(5'h0C, v);
        chk("R9 count mid-transfer in range", 32'((v > 0) && (v < 64) && (v[1:0] == 0)), 1);
        rd(5'h00, v); chk("R9 busy bit", 32'(v[5]), 1);
        wr(5'h00, 32'h04);
        repeat (60) @(negedge clk);
        rd(5'h00, v);
        chk("R8 enable cleared", 32'(v[0]), 0);
        chk("R8 not busy", 32'(v[5]), 0);
        chk("R8 no done", 32'(v[3]), 0);
        chk("R8 no irq", 32'(irq), 0);
        chk("R8 tail untouched", mem[32'h3BC >> 2], 32'hDEAD0000 + 32'hEF);

        summary_and_end();
    end

endmodule